// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous burst memory. Each accepted cycle either loads a fresh external address or steps an internal two-bit beat counter. The two low address bits are then reordered from the loaded start bits and the beat count. The upper bits pass through from the loaded address and stay fixed for the whole burst.

An ordering input picks one of two burst orders. In interleaved order the low bits are the start bits XOR the beat. In linear order they are the start bits plus the beat, wrapping within four words. The ordering is captured with the address when a burst is loaded, so a change on the pin in mid-burst does not disturb the sequence already running.

An active-low clock enable suspends the block: while it is high, every input is ignored and all state holds. A qualifier input marks the cycles that carry an operation. Unqualified cycles also hold state. A new address can be loaded on any qualified cycle, including in the middle of a burst, with no idle cycle in between.

Top module: `bseq_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the loaded address, the captured order and the beat counter, so the next cycle shows `addr_o` = 0 and `beat_o` = 0.
- R2: On an edge with `clk_en_n_i` low, `op_valid_i` high and `adv_i` low, the block loads `addr_i`. The following cycle shows `addr_o` equal to that address and `beat_o` = 0.
- R3: On an edge with `clk_en_n_i` low, `op_valid_i` high and `adv_i` high, `beat_o` increments by one modulo 4.
- R4: When the captured order is interleaved (`mode_i` = 1 at load), `addr_o[1:0]` equals the loaded start bits XOR `beat_o`. From start 1 this gives 1,0,3,2.
- R5: When the captured order is linear (`mode_i` = 0 at load), `addr_o[1:0]` equals the loaded start bits plus `beat_o`, modulo 4. From start 1 this gives 1,2,3,0.
- R6: Bits above bit 1 of `addr_o` never change while advancing. Stepping past the fourth beat returns to the first word of the same burst with no carry into the upper bits.
- R7: While `clk_en_n_i` is high, `addr_o` and `beat_o` hold whatever `addr_i`, `adv_i`, `mode_i` and `op_valid_i` do.
- R8: While `op_valid_i` is low (and `clk_en_n_i` low), `addr_o` and `beat_o` hold.
- R9: `mode_i` is sampled only on a load. Changing it during a burst does not alter the ordering until the next load.
- R10: A load in the middle of a burst takes effect on that edge: the beat restarts at 0 with the new address, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clk_en_n_i | input | 1 | Clock enable, active low; high suspends the block |
| op_valid_i | input | 1 | Qualifies the cycle as an operation |
| adv_i | input | 1 | Low loads `addr_i`; high steps the beat counter |
| mode_i | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current word address |
| beat_o | output | 2 | Index of the current beat within the burst |

## Verification
The bench builds the block with `ADDR_W` = 6, which leaves a four-bit upper field. Start addresses of all-ones and `6'b111100` let a missing wrap show up as a carry into the upper field or a borrow from it. All four start positions are run in both orders. That covers the complete interleaved and linear tables, and the step past beat 3 is taken in each case. Suspend, unqualified cycles, a mode flip in mid-burst and a reload in mid-burst are each driven with conflicting input values, so that any leak would be visible on `addr_o` or `beat_o`.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W    = 2;
    localparam int BURST_LEN = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } ctl_t;

    function automatic beat_t order_low(beat_t start, beat_t beat, order_e ord);
        beat_t r;
        if (ord == ORD_XOR) r = start ^ beat;
        else                r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/bseq_ctl.sv
module bseq_ctl
    import bseq_pkg::*;
(
    input  logic clk_en_n_i,
    input  logic op_valid_i,
    input  logic adv_i,
    output ctl_t ctl_o
);
    logic active;

    always_comb begin
        active     = !clk_en_n_i && op_valid_i;
        ctl_o.load = active && !adv_i;
        ctl_o.step = active && adv_i;
    end

endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o,
    output order_e            ord_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    beat_t start_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= '0;
            ord_o   <= ORD_LINEAR;
        end else if (load_i) begin
            start_q <= addr_i[BEAT_W-1:0];
            ord_o   <= order_e'(mode_i);
        end
    end

    generate
        if (UP_W > 0) begin : g_upper
            logic [UP_W-1:0] upper_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)       upper_q <= '0;
                else if (load_i) upper_q <= addr_i[ADDR_W-1:BEAT_W];
            end
            assign base_o = {upper_q, start_q};
        end else begin : g_no_upper
            assign base_o = start_q;
        end
    endgenerate

    AST_ORD_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(ord_o)); // R9

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  ctl_t  ctl_i,
    output beat_t beat_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || ctl_i.load) beat_o <= '0;
        else if (ctl_i.step)     beat_o <= beat_o + beat_t'(1);
    end

    AST_BEAT_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_i.load |=> beat_o == '0); // R10

    AST_BEAT_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl_i.load && !ctl_i.step |=> $stable(beat_o)); // R8

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clk_en_n_i,
    input  logic              op_valid_i,
    input  logic              adv_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);
    ctl_t              ctl;
    logic [ADDR_W-1:0] base;
    order_e            ord;
    beat_t             beat;
    beat_t             low;

    bseq_ctl u_ctl (
        .clk_en_n_i (clk_en_n_i),
        .op_valid_i (op_valid_i),
        .adv_i      (adv_i),
        .ctl_o      (ctl)
    );

    bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (ctl.load),
        .mode_i (mode_i),
        .addr_i (addr_i),
        .base_o (base),
        .ord_o  (ord)
    );

    bseq_beat_ctr u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ctl_i  (ctl),
        .beat_o (beat)
    );

    always_comb begin
        low    = order_low(base[BEAT_W-1:0], beat, ord);
        addr_o = base;
        addr_o[BEAT_W-1:0] = low;
        beat_o = beat;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> addr_o == '0 && beat_o == '0); // R1

    AST_LOAD_ADDR: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_n_i && op_valid_i && !adv_i |=>
            addr_o == $past(addr_i) && beat_o == '0); // R2

    AST_STEP_BEAT: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_n_i && op_valid_i && adv_i |=>
            beat_o == beat_t'($past(beat_o) + beat_t'(1))); // R3

    AST_XOR_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
        ord == ORD_XOR |-> (addr_o[BEAT_W-1:0] ^ base[BEAT_W-1:0]) == beat_o); // R4

    AST_LIN_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
        ord == ORD_LINEAR |-> beat_t'(addr_o[BEAT_W-1:0] - base[BEAT_W-1:0]) == beat_o); // R5

    AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
        !clk_en_n_i && op_valid_i && adv_i |=>
            addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])); // R6

    AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        clk_en_n_i |=> $stable(addr_o) && $stable(beat_o)); // R7

    AST_UNQUAL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !op_valid_i |=> $stable(addr_o) && $stable(beat_o)); // R8

endmodule

// File: tb/test_bseq_addr_gen.sv
module test_bseq_addr_gen;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_n;
    logic          vld;
    logic          adv;
    logic          mode;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bseq_addr_gen #(.ADDR_W(AW)) i_bseq_addr_gen (
        .clk_i      (clk),
        .rst_i      (rst),
        .clk_en_n_i (en_n),
        .op_valid_i (vld),
        .adv_i      (adv),
        .mode_i     (mode),
        .addr_i     (addr_in),
        .addr_o     (addr_out),
        .beat_o     (beat_out)
    );

    function automatic logic [AW-1:0] model(logic [AW-1:0] st, logic [1:0] b, logic m);
        logic [1:0] lo;
        lo = m ? (st[1:0] ^ b) : (st[1:0] + b);
        return {st[AW-1:2], lo};
    endfunction

    task automatic chk(string req, logic [AW-1:0] ga, logic [AW-1:0] ea,
                       logic [1:0] gb, logic [1:0] eb);
        checks++;
        if (ga !== ea || gb !== eb) begin
            errors++;
            $display("FAIL %s addr=%0h beat=%0d expected addr=%0h beat=%0d",
                     req, ga, gb, ea, eb);
        end
    endtask

    task automatic cyc(logic r, logic e, logic v, logic a, logic m, logic [AW-1:0] ad);
        @(negedge clk);
        rst = r; en_n = e; vld = v; adv = a; mode = m; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h2B);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'h2B);
        chk("R1", addr_out, '0, beat_out, 2'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'h3F);
        chk("R1", addr_out, model('0, 2'd1, 1'b0), beat_out, 2'd1);
    endtask

    task automatic t_burst(logic [AW-1:0] st, logic m);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, m, st);
        chk("R2", addr_out, st, beat_out, 2'd0);
        for (int i = 1; i <= 5; i++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, ~m, ~st);
            chk(m ? "R4 R6 R9" : "R5 R6 R9", addr_out,
                model(st, 2'(i), m), beat_out, 2'(i));
        end
    endtask

    task automatic t_suspend();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h16);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'h16);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b1, i[0], 1'b1, 6'h31);
            chk("R7", addr_out, model(6'h16, 2'd1, 1'b0), beat_out, 2'd1);
        end
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h31);
        chk("R7", addr_out, model(6'h16, 2'd2, 1'b0), beat_out, 2'd2);
    endtask

    task automatic t_unqual();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h0D);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h0D);
        for (int i = 0; i < 2; i++) begin
            cyc(1'b0, 1'b0, 1'b0, i[0], 1'b0, 6'h22);
            chk("R8", addr_out, model(6'h0D, 2'd1, 1'b1), beat_out, 2'd1);
        end
    endtask

    task automatic t_reload();
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h1A);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h1A);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h1A);
        chk("R10", addr_out, model(6'h1A, 2'd2, 1'b1), beat_out, 2'd2);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h27);
        chk("R10", addr_out, 6'h27, beat_out, 2'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h00);
        chk("R10 R5", addr_out, model(6'h27, 2'd1, 1'b0), beat_out, 2'd1);
    endtask

    initial begin
        rst = 1'b1; en_n = 1'b0; vld = 1'b0; adv = 1'b0; mode = 1'b0; addr_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", addr_out, '0, beat_out, 2'd0);
        t_reset();
        for (int s = 0; s < 4; s++) begin
            t_burst(AW'({4'b1111, 2'(s)}), 1'b1);
            t_burst(AW'({4'b0101, 2'(s)}), 1'b0);
        end
        t_burst(6'h3F, 1'b0);
        t_burst(6'h3C, 1'b1);
        t_suspend();
        t_unqual();
        t_reload();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule